// File: doc/BRIEF.md
# ACPI Power Management Timer

A free-running power management timer that software reads as one 32-bit word. The count sits in the low bits of that word and the bits above it always read as zero. The count advances once every four clock cycles. The clock comes from the 14.31818 MHz reference, so the count rate is the nominal 3.579545 MHz. A qualifier input stops the count whenever the system is not in its fully running state.

Each time a chosen count bit (bit 22 by default) falls from one to zero, a sticky overflow status bit is raised. At the default rate this happens about every 2.3435 seconds. Software clears the status by writing a one to it. A separately written enable bit lets the status drive an interrupt request.

Reads use a valid/ready request and a valid/ready response. An accepted request captures the whole count in one cycle, so a read can never mix bits from two different count values. The response word stays put until the consumer takes it. The block accepts no new request while a response is still waiting, which is the only back-pressure it applies.

Top module: `acpi_pm_timer`

## Requirements
- R1: `rsp_data` is `REG_W` (32) bits wide. The count occupies bits `CNT_W-1:0`, and every bit from `CNT_W` upward reads as zero.
- R2: While `run` is high, the count increases by exactly one on every `DIV`-th (fourth) rising clock edge. The first increment comes on the `DIV`-th edge after reset is released. The count wraps from all ones to zero.
- R3: An active-low `rst_n` clears the count, the status, the enable and `rsp_valid`. While `run` is low, the count holds its value.
- R4: `ovf_sts` becomes 1 on the edge where an increment takes count bit `EDGE_BIT` (22 by default, bits numbered from 0) from 1 to 0, and this includes the wrap to zero. Nothing else sets it.
- R5: `ovf_sts` stays set until an edge with `clr_we`=1 and `clr_wd`=1. A clear write with `clr_wd`=0 has no effect. If a set and a clear fall on the same edge, the status ends at 1.
- R6: `ovf_en` takes the value of `en_wd` on every edge with `en_we`=1. `irq` is high exactly while `ovf_sts` and `ovf_en` are both 1.
- R7: `rd_ready` is high exactly when no response is pending. A request accepted on an edge returns the count as it stood before that edge's increment. `rsp_valid` rises on the same edge.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values. `rsp_valid` falls on the edge where `rsp_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock (14.31818 MHz reference) |
| rst_n | input | 1 | System reset, asynchronous, active low |
| run | input | 1 | High while the system is in the fully running state |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Zero-extended count snapshot |
| clr_we | input | 1 | Status write strobe |
| clr_wd | input | 1 | Status write data; a 1 clears the status |
| en_we | input | 1 | Enable write strobe |
| en_wd | input | 1 | Enable write data |
| ovf_sts | output | 1 | Sticky overflow status |
| ovf_en | output | 1 | Overflow interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input changes only between clock edges and that `rsp_ready` is a plain level, with no ordering promise toward `rd_valid`. They also assume that `EDGE_BIT` lies below `CNT_W` and that `CNT_W` is below `REG_W`.

The bench drives all inputs on falling edges from seeded random draws, so each input stays stable around every rising edge. It shrinks the counter to 10 bits, with bit 8 as the watched bit, so that many falling edges of that bit, and wraps of the whole counter, fit within the run. It drops `run` at random to cover the hold behaviour. It overlaps clear writes with set events and stalls `rsp_ready` to hold responses in place.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int unsigned PMT_REG_W    = 32;
  localparam int unsigned PMT_CNT_W    = 24;
  localparam int unsigned PMT_EDGE_BIT = 22;
  localparam int unsigned PMT_DIV      = 4;
endpackage

// File: rtl/pmt_prescale.sv
module pmt_prescale #(
  parameter int unsigned DIV = pmt_pkg::PMT_DIV
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R2: ticks are never back to back when dividing
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int unsigned CNT_W    = pmt_pkg::PMT_CNT_W,
  parameter int unsigned EDGE_BIT = pmt_pkg::PMT_EDGE_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             fall
);
  logic inc;

  assign inc  = tick & run;
  // the watched bit drops exactly when it and all bits below it are ones
  assign fall = inc & (&count[EDGE_BIT:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> count == $past(count) + 1'b1);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run) |=> $stable(count));
endmodule

// File: rtl/pmt_status.sv
module pmt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic clr_we,
  input  logic clr_wd,
  input  logic en_we,
  input  logic en_wd,
  output logic sts,
  output logic en,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= 1'b0;
    else if (fall) sts <= 1'b1;
    else if (clr_we && clr_wd) sts <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else if (en_we) en <= en_wd;
  end

  assign irq = sts & en;

  assert_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> sts);

  assert_only_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts && !fall) |=> !sts);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !(clr_we && clr_wd)) |=> sts);

  assert_en_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en == $past(en_wd));
endmodule

// File: rtl/pmt_read_port.sv
module pmt_read_port #(
  parameter int unsigned CNT_W = pmt_pkg::PMT_CNT_W,
  parameter int unsigned REG_W = pmt_pkg::PMT_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [REG_W-1:0] rsp_data
);
  assign rd_ready = !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rsp_valid) begin
      if (rsp_ready) rsp_valid <= 1'b0;
    end else if (rd_valid) begin
      rsp_valid <= 1'b1;
      rsp_data  <= REG_W'(count);
    end
  end

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (rsp_valid && rsp_data == REG_W'($past(count))));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[REG_W-1:CNT_W] == '0);
endmodule

// File: rtl/acpi_pm_timer.sv
module acpi_pm_timer #(
  parameter int unsigned CNT_W    = pmt_pkg::PMT_CNT_W,
  parameter int unsigned EDGE_BIT = pmt_pkg::PMT_EDGE_BIT,
  parameter int unsigned DIV      = pmt_pkg::PMT_DIV,
  parameter int unsigned REG_W    = pmt_pkg::PMT_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [REG_W-1:0] rsp_data,
  input  logic             clr_we,
  input  logic             clr_wd,
  input  logic             en_we,
  input  logic             en_wd,
  output logic             ovf_sts,
  output logic             ovf_en,
  output logic             irq
);
  logic             tick;
  logic             fall;
  logic [CNT_W-1:0] count;

  pmt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pmt_counter #(.CNT_W(CNT_W), .EDGE_BIT(EDGE_BIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .count(count), .fall(fall)
  );

  pmt_status u_sts (
    .clk(clk), .rst_n(rst_n), .fall(fall),
    .clr_we(clr_we), .clr_wd(clr_wd), .en_we(en_we), .en_wd(en_wd),
    .sts(ovf_sts), .en(ovf_en), .irq(irq)
  );

  pmt_read_port #(.CNT_W(CNT_W), .REG_W(REG_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .count(count),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // R6: the interrupt follows status and enable
  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_sts && ovf_en));
endmodule

// File: tb/test_acpi_pm_timer.sv
module test_acpi_pm_timer;
  localparam int unsigned CW = 10;
  localparam int unsigned EB = 8;
  localparam int unsigned DV = 4;
  localparam int unsigned RW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, rd_valid = 1'b0, rsp_ready = 1'b0;
  logic clr_we = 1'b0, clr_wd = 1'b0, en_we = 1'b0, en_wd = 1'b0;
  logic rd_ready, rsp_valid, ovf_sts, ovf_en, irq;
  logic [RW-1:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;

  acpi_pm_timer #(.CNT_W(CW), .EDGE_BIT(EB), .DIV(DV), .REG_W(RW)) i_acpi_pm_timer (
    .clk(clk), .rst_n(rst_n), .run(run),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .clr_we(clr_we), .clr_wd(clr_wd), .en_we(en_we), .en_wd(en_wd),
    .ovf_sts(ovf_sts), .ovf_en(ovf_en), .irq(irq)
  );

  // reference model built from the requirements
  int unsigned   m_div;
  logic [CW-1:0] m_cnt;
  logic          m_sts, m_en, m_rv;
  logic [CW-1:0] m_rd;

  function automatic logic falls(input logic [CW-1:0] c);
    logic [CW-1:0] n;
    n = c + 1'b1;
    return c[EB] && !n[EB];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= 0; m_cnt <= '0; m_sts <= 1'b0; m_en <= 1'b0;
      m_rv <= 1'b0; m_rd <= '0;
    end else begin
      if (m_div == DV - 1 && run) begin
        m_cnt <= m_cnt + 1'b1;
        if (falls(m_cnt)) m_sts <= 1'b1;
        else if (clr_we && clr_wd) m_sts <= 1'b0;
      end else if (clr_we && clr_wd) m_sts <= 1'b0;
      if (en_we) m_en <= en_wd;
      if (m_rv) begin
        if (rsp_ready) m_rv <= 1'b0;
      end else if (rd_valid) begin
        m_rv <= 1'b1; m_rd <= m_cnt;
      end
      m_div <= (m_div == DV - 1) ? 0 : m_div + 1;
    end
  end

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check("R8 rsp_valid", RW'(rsp_valid), RW'(m_rv));
      check("R7 rd_ready", RW'(rd_ready), RW'(!m_rv));
      if (m_rv) begin
        check("R7 data", RW'(rsp_data[CW-1:0]), RW'(m_rd));
        check("R1 reserved", RW'(rsp_data[RW-1:CW]), '0);
      end
      check("R4 sts", RW'(ovf_sts), RW'(m_sts));
      check("R6 en", RW'(ovf_en), RW'(m_en));
      check("R6 irq", RW'(irq), RW'(m_sts && m_en));
    end
  end

  task automatic do_read(input string tag);
    @(negedge clk);
    rd_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    rd_valid = 1'b0;
    check(tag, RW'(rsp_data[CW-1:0]), RW'(m_rd));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 rsp_valid", RW'(rsp_valid), '0);
    check("R3 irq", RW'(irq), '0);
    check("R3 sts", RW'(ovf_sts), '0);
    check("R3 en", RW'(ovf_en), '0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    run = 1'b1;
    // R2: 40 cycles of running gives ten increments
    repeat (40) @(negedge clk);
    check("R2 count after 40", RW'(m_cnt), RW'(10));
    do_read("R2 read");
    // R3: count holds while not running
    run = 1'b0;
    repeat (37) @(negedge clk);
    do_read("R3 hold read");
    check("R3 hold value", RW'(rsp_data[CW-1:0]), RW'(10));
    // R6: enable before first overflow
    en_we = 1'b1; en_wd = 1'b1;
    @(negedge clk);
    en_we = 1'b0;
    run = 1'b1;
    // run until status rises
    for (int i = 0; i < 4000 && !m_sts; i++) @(negedge clk);
    check("R4 status raised", RW'(ovf_sts), RW'(1));
    check("R6 irq raised", RW'(irq), RW'(1));
    // R5: writing zero has no effect
    clr_we = 1'b1; clr_wd = 1'b0;
    @(negedge clk);
    clr_we = 1'b0;
    @(negedge clk);
    check("R5 zero write keeps", RW'(ovf_sts), RW'(1));
    clr_we = 1'b1; clr_wd = 1'b1;
    @(negedge clk);
    clr_we = 1'b0;
    check("R5 one write clears", RW'(ovf_sts), RW'(m_sts));
    check("R6 irq after clear", RW'(irq), RW'(m_sts && m_en));
    // random mixed traffic
    for (int i = 0; i < 60000; i++) begin
      run       = ($urandom % 8) != 0;
      rd_valid  = ($urandom % 3) == 0;
      rsp_ready = ($urandom % 2) == 0;
      clr_we    = ($urandom % 6) == 0;
      clr_wd    = ($urandom % 2) == 0;
      en_we     = ($urandom % 40) == 0;
      en_wd     = ($urandom % 3) != 0;
      @(negedge clk);
    end
    run = 1'b0; rd_valid = 1'b0; clr_we = 1'b0; en_we = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule